// File: doc/BRIEF.md
# Overlapped Serial ADC Stream Master

This block is the host side of a synchronous serial link to a 12-bit sampling converter. It drives a chip select, a serial clock and a command line, and it reads a result line and a conversion-in-progress line. After a start request it holds chip select low and streams without a break. Each conversion takes a 16-clock frame. The frame opens with an 8-clock command byte, and an 8-clock byte of zeros follows it. The 12 result bits of a conversion arrive across the zero byte and the first five clocks of the next command byte. This means the command for conversion n+1 goes out while result n is still being read.

The serial clock half period is a count of system clocks. Any value shorter than the converter's minimum high and low time is raised to that minimum. The user supplies the seven command bits that follow the start bit. Each completed result appears on a 12-bit output with a one-cycle strobe. A stop request takes effect at the next frame boundary. The block then sends one zero byte, which carries no start bit, so that the last result is clocked out, and then releases chip select. Two sticky error flags report a missing busy indication and a conversion that took longer than the hold limit of the converter's sampling stage.

Top module: `adc_stream_master`

## Requirements
- R1: After reset and while idle: cs_n=1, dclk=0, din=0, res_valid=0, err_busy=0, err_timeout=0.
- R2: A start request while idle drives cs_n low. The first dclk rise comes one full half period after cs_n falls.
- R3: The half period is H = max(half_cycles, MIN_HALF) system clocks, with MIN_HALF = ceil(MIN_DCLK_NS * SYS_CLK_MHZ / 1000), which is 40 by default. Every dclk high phase and every dclk low phase lasts exactly H system clocks.
- R4: Each command byte goes out MSB first as {1, ctrl_bits[6:0]}, so the start bit is at bit 7. ctrl_bits is sampled when the byte begins. din changes only at the system edge where dclk falls.
- R5: The stream is a sequence of 16-clock frames. Frame positions 0..7 carry a command byte and positions 8..15 carry din=0, so one conversion starts every 16 dclk periods.
- R6: dout is sampled at dclk rises. For a command byte whose first rise is rise k, result bit 11 is taken at rise k+9 and bit 0 at rise k+20. At the cycle that follows the capture of bit 0, result holds the 12 bits and res_valid is high for exactly one system clock.
- R7: A stop request ends the stream after the current frame. One zero byte follows, and cs_n rises at its 8th dclk fall. A run with N conversions therefore has 16N+8 dclk rises and delivers N results.
- R8: If busy is low at rise k+8 (the rise after a command byte with S=1), err_busy becomes 1 and stays set.
- R9: If bit 0 of a result has not been captured within TIMEOUT_US*SYS_CLK_MHZ system clocks after the last command rise, err_timeout becomes 1 and stays set.
- R10: An accepted start clears both error flags. Start while streaming and stop while idle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin streaming (one-cycle pulse) |
| stop | input | 1 | End streaming at next frame boundary (pulse) |
| ctrl_bits | input | 7 | Command bits that follow the start bit |
| half_cycles | input | HDIV_W | Requested dclk half period in system clocks |
| result | output | 12 | Last completed conversion result |
| res_valid | output | 1 | One-cycle strobe for a new result |
| err_busy | output | 1 | Sticky: busy not seen after a command |
| err_timeout | output | 1 | Sticky: conversion exceeded hold limit |
| cs_n | output | 1 | Converter chip select, active low |
| dclk | output | 1 | Serial clock to converter |
| din | output | 1 | Serial command line to converter |
| dout | input | 1 | Serial result line from converter |
| busy | input | 1 | Conversion-in-progress line from converter |

## Verification
A frame position counter that slips by a single count shifts every later result by one bit, and it also moves the 8-clock flush. The fault is visible on the first res_valid after the slip, in the result value and in the total rise count once cs_n rises. A stale command register or a lost start bit appears in the command byte the converter model receives within the same frame. A wrong divider state shows up as a high or low phase whose length differs from H, within one dclk period. A wrong error-flag state is visible on err_busy or err_timeout one cycle after the offending rise or count.

// File: rtl/asc_pkg.sv
// Shared constants and types for the overlapped serial ADC stream master.
// Assumes a 16-clock frame: command byte at positions 0..7, zeros at 8..15.
package asc_pkg;
    localparam int RES_W  = 12;
    localparam int BYTE_W = 8;

    // Frame positions whose behaviour other logic decodes.
    localparam logic [3:0] POS_CMD_LAST  = 4'd7;   // last command bit latched
    localparam logic [3:0] POS_BUSY      = 4'd8;   // converter shows busy
    localparam logic [3:0] POS_BIT_FIRST = 4'd9;   // result bit 11
    localparam logic [3:0] POS_BIT_LAST  = 4'd4;   // result bit 0 (next frame)
    localparam logic [3:0] POS_FRAME_END = 4'd15;

    typedef enum logic [1:0] {
        ASC_IDLE,
        ASC_STREAM,
        ASC_FLUSH
    } asc_state_e;
endpackage

// File: rtl/asc_clkgen.sv
// Serial clock divider. While enabled, dclk toggles every `half` system
// clocks, starting low. rise_p/fall_p flag the system edge on which dclk
// goes high/low. Assumes half >= 1 and that half is held stable while enabled.
module asc_clkgen #(
    parameter int HDIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [HDIV_W-1:0] half,
    output logic              dclk,
    output logic              rise_p,
    output logic              fall_p
);
    localparam logic [HDIV_W-1:0] ONE = HDIV_W'(1);

    logic [HDIV_W-1:0] cnt;
    logic              wrap;

    // Phase end: the divider count has reached the half period.
    assign wrap   = en && (cnt == half - ONE);
    assign rise_p = wrap && !dclk;
    assign fall_p = wrap && dclk;

    // Divider count and serial clock level.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt  <= '0;
            dclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            dclk <= ~dclk;
        end else begin
            cnt  <= cnt + ONE;
        end
    end
endmodule

// File: rtl/asc_rx.sv
// Result collector. It starts a conversion on conv_go, then shifts in dout on
// the dclk rises at frame positions 9..15 and 0..4 and presents the 12-bit
// word with a one-cycle strobe. It checks busy one rise after the command and
// times the conversion against a cycle limit. Assumes pos is the frame
// position of the current dclk rise.
module asc_rx
    import asc_pkg::*;
#(
    parameter int TMO_CYC = 320000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             rise_p,
    input  logic [3:0]       pos,
    input  logic             conv_go,
    input  logic             dout,
    input  logic             busy,
    output logic [RES_W-1:0] result,
    output logic             res_valid,
    output logic             err_busy,
    output logic             err_timeout
);
    localparam int              TMO_W   = $clog2(TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LIM = TMO_W'(TMO_CYC - 1);

    logic             col;
    logic [RES_W-2:0] sh;
    logic [TMO_W-1:0] tcnt;
    logic             in_win;
    logic             take;
    logic             last;

    assign in_win = (pos >= POS_BIT_FIRST) || (pos <= POS_BIT_LAST);
    assign take   = rise_p && col && in_win;
    assign last   = take && (pos == POS_BIT_LAST);

    // Conversion tracking, bit shifting and result presentation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col       <= 1'b0;
            sh        <= '0;
            result    <= '0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= 1'b0;
            if (clear) begin
                col <= 1'b0;
            end else if (conv_go) begin
                col <= 1'b1;
            end else if (last) begin
                col       <= 1'b0;
                result    <= {sh, dout};
                res_valid <= 1'b1;
            end
            if (take) begin
                sh <= {sh[RES_W-3:0], dout};
            end
        end
    end

    // Conversion age counter, saturating at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !col || conv_go) begin
            tcnt <= '0;
        end else if (tcnt != TMO_LIM) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // Sticky error flags, cleared by an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            err_busy    <= 1'b0;
            err_timeout <= 1'b0;
        end else begin
            if (rise_p && col && (pos == POS_BUSY) && !busy) begin
                err_busy <= 1'b1;
            end
            if (col && (tcnt == TMO_LIM) && !last) begin
                err_timeout <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_stream_master.sv
// Top of the overlapped serial ADC stream master. It sequences 16-clock
// frames: a command byte {1, ctrl_bits} on din, then eight zeros, while
// asc_rx collects the previous result. A stop ends the stream at the next
// frame boundary with one zero byte. Assumes start/stop are synchronous
// pulses and half_cycles fits the minimum half period.
module adc_stream_master
    import asc_pkg::*;
#(
    parameter int SYS_CLK_MHZ = 200,
    parameter int MIN_DCLK_NS = 200,
    parameter int TIMEOUT_US  = 1600,
    parameter int HDIV_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              stop,
    input  logic [6:0]        ctrl_bits,
    input  logic [HDIV_W-1:0] half_cycles,
    output logic [RES_W-1:0]  result,
    output logic              res_valid,
    output logic              err_busy,
    output logic              err_timeout,
    output logic              cs_n,
    output logic              dclk,
    output logic              din,
    input  logic              dout,
    input  logic              busy
);
    localparam int MIN_HALF = (MIN_DCLK_NS * SYS_CLK_MHZ + 999) / 1000;
    localparam int TMO_CYC  = TIMEOUT_US * SYS_CLK_MHZ;
    localparam logic [HDIV_W-1:0] MIN_H = HDIV_W'(MIN_HALF);

    asc_state_e        state;
    logic [3:0]        pos;
    logic [BYTE_W-1:0] txbyte;
    logic              s_q;
    logic              stop_l;
    logic [HDIV_W-1:0] half_q;
    logic [HDIV_W-1:0] eff_half;
    logic              go;
    logic              rise_p;
    logic              fall_p;
    logic              conv_go;

    assign eff_half = (half_cycles < MIN_H) ? MIN_H : half_cycles;
    assign go       = start && (state == ASC_IDLE);
    assign conv_go  = rise_p && (pos == POS_CMD_LAST) && s_q;

    // Frame sequencing, command shifting and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ASC_IDLE;
            cs_n   <= 1'b1;
            din    <= 1'b0;
            pos    <= '0;
            txbyte <= '0;
            s_q    <= 1'b0;
            stop_l <= 1'b0;
            half_q <= MIN_H;
        end else if (go) begin
            state  <= ASC_STREAM;
            cs_n   <= 1'b0;
            pos    <= '0;
            txbyte <= {1'b1, ctrl_bits};
            din    <= 1'b1;
            s_q    <= 1'b1;
            stop_l <= 1'b0;
            half_q <= eff_half;
        end else if (state != ASC_IDLE) begin
            if (stop && state == ASC_STREAM) begin
                stop_l <= 1'b1;
            end
            if (fall_p) begin
                if (pos == POS_FRAME_END) begin
                    pos <= '0;
                    if (stop_l) begin
                        state  <= ASC_FLUSH;
                        txbyte <= '0;
                        din    <= 1'b0;
                        s_q    <= 1'b0;
                    end else begin
                        txbyte <= {1'b1, ctrl_bits};
                        din    <= 1'b1;
                        s_q    <= 1'b1;
                    end
                end else if (state == ASC_FLUSH && pos == POS_CMD_LAST) begin
                    state <= ASC_IDLE;
                    cs_n  <= 1'b1;
                    din   <= 1'b0;
                    pos   <= '0;
                end else begin
                    pos    <= pos + 4'd1;
                    din    <= txbyte[BYTE_W-2];
                    txbyte <= txbyte << 1;
                end
            end
        end
    end

    asc_clkgen #(
        .HDIV_W (HDIV_W)
    ) i_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (state != ASC_IDLE),
        .half   (half_q),
        .dclk   (dclk),
        .rise_p (rise_p),
        .fall_p (fall_p)
    );

    asc_rx #(
        .TMO_CYC (TMO_CYC)
    ) i_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (go),
        .rise_p      (rise_p),
        .pos         (pos),
        .conv_go     (conv_go),
        .dout        (dout),
        .busy        (busy),
        .result      (result),
        .res_valid   (res_valid),
        .err_busy    (err_busy),
        .err_timeout (err_timeout)
    );
endmodule

// File: rtl/asc_checker.sv
// Protocol checker for adc_stream_master, attached by bind. It watches the
// serial pins and status outputs only. Assumes MIN_HALF matches the top.
module asc_checker #(
    parameter int MIN_HALF = 40
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic cs_n,
    input logic dclk,
    input logic din,
    input logic res_valid,
    input logic err_busy,
    input logic err_timeout
);
    logic [15:0] hi_cnt;

    // Length of the current dclk high phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !dclk) hi_cnt <= '0;
        else                 hi_cnt <= hi_cnt + 16'd1;
    end

    a_r1_dclk_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |-> !cs_n);
    a_r1_idle_din_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !din);
    a_r3_high_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dclk) |-> (hi_cnt >= 16'(MIN_HALF)));
    a_r4_din_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (dclk && $past(dclk)) |-> $stable(din));
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    a_r7_cs_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !dclk);
    a_r8_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_busy && !start) |=> err_busy);
    a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_timeout && !start) |=> err_timeout);
endmodule

bind adc_stream_master asc_checker #(
    .MIN_HALF (MIN_HALF)
) i_asc_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cs_n        (cs_n),
    .dclk        (dclk),
    .din         (din),
    .res_valid   (res_valid),
    .err_busy    (err_busy),
    .err_timeout (err_timeout)
);

// File: tb/test_adc_stream_master.sv
// Directed bench with a converter model. It checks frames, results, stop
// flush, divider timing and error flags through the block's ports.
module test_adc_stream_master;
    localparam int MINH = 40;
    localparam int TMO  = 10 * 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        stop = 1'b0;
    logic [6:0]  ctrl_bits = 7'h00;
    logic [7:0]  half_cycles = 8'd40;
    logic [11:0] result;
    logic        res_valid, err_busy, err_timeout, cs_n, dclk, din;
    logic        dout = 1'b0;
    logic        busy = 1'b0;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // converter model state
    int         e = 0, n_ctrl = 0, n_res = 0, filler_bad = 0, flush_cnt = 0, flush_bad = 0;
    logic [7:0] rxsh = 8'h00, last_byte = 8'h00;
    logic [11:0] data_m = 12'h000;
    logic [11:0] exp_q [0:63];
    bit         conv_act = 1'b0, busy_en = 1'b1;

    // pin timing monitors
    int  run = 0, min_hi = 0, max_hi = 0, min_lo = 0, max_lo = 0;
    int  t_csfall = 0, t_rise1 = 0, din_bad = 0;
    bit  in_cs = 1'b0, pd = 1'b0, got_rise = 1'b0, pdin = 1'b0, pdk = 1'b0;

    always #2.5 clk = ~clk;

    adc_stream_master #(.TIMEOUT_US(10)) i_adc_stream_master (
        .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
        .ctrl_bits(ctrl_bits), .half_cycles(half_cycles),
        .result(result), .res_valid(res_valid), .err_busy(err_busy),
        .err_timeout(err_timeout), .cs_n(cs_n), .dclk(dclk), .din(din),
        .dout(dout), .busy(busy));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_all();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            finish_all();
        end
    end

    // Converter model: receive command bits on dclk rises.
    always @(posedge dclk) if (!cs_n) begin
        rxsh = {rxsh[6:0], din};
        if (e % 16 == 7) begin
            if (rxsh[7]) begin
                n_ctrl++;
                last_byte = rxsh;
                data_m = {rxsh[6:0], 5'(n_ctrl)};
                exp_q[(n_ctrl - 1) % 64] = data_m;
                conv_act = 1'b1;
            end else begin
                flush_cnt++;
                if (rxsh != 8'h00) flush_bad++;
            end
        end
        if (e % 16 == 15 && rxsh != 8'h00) filler_bad++;
        e++;
    end

    // Converter model: drive busy and result bits after dclk falls.
    always @(negedge dclk) if (!cs_n) begin
        int q;
        q = e % 16;
        busy = 1'b0;
        dout = 1'b0;
        if (conv_act && q == 5) conv_act = 1'b0;
        if (conv_act) begin
            if (q == 8)      busy = busy_en;
            else if (q >= 9) dout = data_m[20 - q];
            else if (q <= 4) dout = data_m[4 - q];
        end
    end

    always @(posedge cs_n) begin
        dout = 1'b0;
        busy = 1'b0;
    end

    // Result monitor (R6): compare each strobe with the model's value.
    always @(negedge clk) if (rst_n && res_valid) begin
        chk(result == exp_q[n_res % 64], "R6 result", result, exp_q[n_res % 64]);
        n_res++;
    end

    // Phase length, first-rise and din stability monitors.
    always @(negedge clk) begin
        if (!cs_n) begin
            if (!in_cs) t_csfall = cyc;
            if (in_cs && dclk != pd) begin
                if (pd) begin
                    if (run < min_hi) min_hi = run;
                    if (run > max_hi) max_hi = run;
                end else begin
                    if (run < min_lo) min_lo = run;
                    if (run > max_lo) max_lo = run;
                end
                if (dclk && !got_rise) begin
                    got_rise = 1'b1;
                    t_rise1 = cyc;
                end
                run = 1;
            end else begin
                run++;
            end
            in_cs = 1'b1;
            pd = dclk;
        end else begin
            in_cs = 1'b0;
            run = 0;
            pd = 1'b0;
        end
        if (dclk && pdk && din != pdin) din_bad++;
        pdk = dclk;
        pdin = din;
    end

    task automatic clr_model();
        e = 0; n_ctrl = 0; n_res = 0; filler_bad = 0; flush_cnt = 0; flush_bad = 0;
        min_hi = 1 << 20; max_hi = 0; min_lo = 1 << 20; max_lo = 0;
        got_rise = 1'b0; din_bad = 0; conv_act = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_res(input int n);
        while (n_res < n) @(negedge clk);
    endtask

    task automatic wait_idle();
        while (!cs_n) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic run_stream(input int h, input logic [6:0] c, input int nres);
        clr_model();
        half_cycles = 8'(h);
        ctrl_bits = c;
        pulse_start();
        wait_res(nres);
        pulse_stop();
        wait_idle();
    endtask

    // Common end-of-run frame checks (R5, R7).
    task automatic chk_frames(input string tag);
        chk(e == 16 * n_ctrl + 8, {"R7 rise count ", tag}, e, 16 * n_ctrl + 8);
        chk(n_res == n_ctrl, {"R7 results delivered ", tag}, n_res, n_ctrl);
        chk(flush_cnt == 1 && flush_bad == 0, {"R7 single zero flush ", tag}, flush_cnt, 1);
        chk(filler_bad == 0, {"R5 zero filler ", tag}, filler_bad, 0);
        chk(din_bad == 0, {"R4 din steady while high ", tag}, din_bad, 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(cs_n && !dclk && !din, "R1 idle pins", {cs_n, dclk, din}, 3'b100);
        chk(!res_valid && !err_busy && !err_timeout, "R1 idle status",
            {res_valid, err_busy, err_timeout}, 0);
    endtask

    task automatic t_normal();
        run_stream(60, 7'h35, 3);
        chk(last_byte == 8'hB5, "R4 command byte with start bit", last_byte, 8'hB5);
        chk(min_hi == 60 && max_hi == 60, "R3 high phase", max_hi, 60);
        chk(min_lo == 60 && max_lo == 60, "R3 low phase", max_lo, 60);
        chk(t_rise1 - t_csfall == 60, "R2 setup before first rise", t_rise1 - t_csfall, 60);
        chk_frames("normal");
        chk(!err_busy && !err_timeout, "R8 R9 no error on good run", {err_busy, err_timeout}, 0);
    endtask

    task automatic t_clamp();
        run_stream(5, 7'h01, 1);
        chk(min_hi == MINH && max_hi == MINH, "R3 clamp high", max_hi, MINH);
        chk(min_lo == MINH && max_lo == MINH, "R3 clamp low", min_lo, MINH);
        chk_frames("clamp");
    endtask

    task automatic t_change_and_ignore();
        clr_model();
        half_cycles = 8'd40;
        ctrl_bits = 7'h11;
        pulse_start();
        wait_res(1);
        ctrl_bits = 7'h6A;
        pulse_start();                 // R10: start while streaming ignored
        wait_res(4);
        pulse_stop();
        wait_idle();
        chk(last_byte == 8'hEA, "R4 new command bits used", last_byte, 8'hEA);
        chk_frames("restart ignored R10");
        stop = 1'b1;                   // R10: stop while idle ignored
        repeat (200) begin
            @(negedge clk);
            stop = 1'b0;
            if (!cs_n || dclk) break;
        end
        chk(cs_n && !dclk && !din, "R10 stop while idle", {cs_n, dclk, din}, 3'b100);
    endtask

    task automatic t_early_stop();
        clr_model();
        half_cycles = 8'd40;
        ctrl_bits = 7'h7F;
        pulse_start();
        repeat (5) @(negedge clk);
        pulse_stop();
        wait_idle();
        chk(n_ctrl == 1 && e == 24, "R7 stop in first byte", e, 24);
        chk(n_res == 1, "R7 early stop result", n_res, 1);
    endtask

    task automatic t_busy_fault();
        busy_en = 1'b0;
        run_stream(40, 7'h22, 2);
        busy_en = 1'b1;
        chk(err_busy, "R8 missing busy flagged", err_busy, 1);
        chk(!err_timeout, "R9 no timeout on fast run", err_timeout, 0);
        chk_frames("busy fault");
    endtask

    task automatic t_timeout_and_clear();
        run_stream(100, 7'h0F, 1);
        chk(err_timeout, "R9 slow conversion flagged", err_timeout, 1);
        chk(!err_busy, "R8 busy present on slow run", err_busy, 0);
        clr_model();
        half_cycles = 8'd40;
        pulse_start();
        chk(!err_timeout && !err_busy && !cs_n, "R10 start clears errors",
            {err_timeout, err_busy, cs_n}, 0);
        wait_res(1);
        pulse_stop();
        wait_idle();
        chk(!err_timeout, "R9 fast run after clear", err_timeout, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_normal();
        t_clamp();
        t_change_and_ignore();
        t_early_stop();
        t_busy_fault();
        t_timeout_and_clear();
        finish_all();
    end
endmodule